// File: doc/BRIEF.md
# Multi-Waveform Low-Frequency Oscillator

This block is the modulation source of one synthesizer voice. An 8-bit phase advances by one each time a reload counter, decremented once per sample tick, runs out. The counter's period comes from a 5-bit rate code through a piecewise formula. The formula gives four evenly spaced periods in each of eight octave bands, and the period halves from one band to the next.

Two values are derived from that phase. The first is an amplitude-modulation value and the second is a pitch-modulation value. Each has its own waveform select and its own 3-bit depth. The pitch waveforms are biased to two's complement where the shape needs it. A one-cycle restart request returns the phase to zero. A write strobe for the rate code restarts only the period count. Applying these values to volume or pitch is left to the surrounding voice logic.

Top module: `lfo_core`

## Requirements
- R1: For rate code N, with S = N>>2, M = (~N)&3 and G = 128>>S, the period is P = 4·(G−1) + G·(M+1) ticks. Examples: N=31 gives 1, N=30 gives 2, N=13 gives 108 and N=0 gives 1020.
- R2: Each cycle with `tick` high decrements the counter. When the counter reaches zero, the phase advances by one, modulo 256, and the counter reloads P. Counted from a restart, the phase equals floor(ticks/P) mod 256.
- R3: When `phase_restart` is high, the phase is set to 0 and the counter reloads P from the current `rate_code`.
- R4: When `rate_load` is high, the counter reloads P from the current `rate_code` and the phase keeps its value.
- R5: The amplitude waveform is selected by `amp_wave`. Code 0 gives a sawtooth equal to the phase. Code 1 gives a square that is 255 when phase bit 7 is set and 0 otherwise.
- R6: Amplitude triangle (code 2): the low seven phase bits are inverted when phase bit 7 is set, and the result is shifted left by one.
- R7: The pitch waveform is selected by `pitch_wave` with the same codes. Sawtooth (code 0) is the phase. Square (code 1) is 0x80 when phase bit 7 is set and 0x7F otherwise. Triangle (code 2) is the amplitude triangle minus 0x80, modulo 256.
- R8: Noise (code 3) on both outputs is (phase>>3) XOR (phase<<3) XOR (phase AND 0xE3), truncated to 8 bits.
- R9: Each output is its waveform value shifted right logically by 8 minus its depth code. Depth 0 therefore gives 0 and depth 7 gives half scale.
- R10: Outputs are registered. They update one clock after the phase or the selects change. Both outputs are 0 while `rst` is high.
- R11: A tick in the same cycle as `phase_restart` or `rate_load` is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample tick, one count per cycle high |
| rate_code | input | 5 | Oscillator rate code |
| rate_load | input | 1 | Reload the period counter from rate_code |
| phase_restart | input | 1 | Return the phase to zero and reload the counter |
| amp_wave | input | 2 | Amplitude waveform select |
| amp_depth | input | 3 | Amplitude depth code |
| pitch_wave | input | 2 | Pitch waveform select |
| pitch_depth | input | 3 | Pitch depth code |
| amp_mod | output | 8 | Amplitude modulation value |
| pitch_mod | output | 8 | Pitch modulation value |

## Verification
The bench builds the block with its default parameters: a 5-bit rate code, an 8-bit phase and a 10-bit counter. At these sizes the fastest rate codes (periods 1 and 2) let a full phase wrap past 255 and every high-phase shape be reached within a few hundred ticks. The slowest code (period 1020) is still short enough to run through two whole periods plus a partial one. Mid-period reloads are placed a known number of ticks before the next phase step. This exposes any lost or extra count on either side of the reload.

// File: rtl/lfo_pkg.sv
package lfo_pkg;
  localparam int PH_W = 8;

  typedef enum logic [1:0] {
    WV_SAW   = 2'd0,
    WV_SQR   = 2'd1,
    WV_TRI   = 2'd2,
    WV_NOISE = 2'd3
  } wave_e;

  // Period in ticks for a rate code; BAND_SH sets the slowest band scale.
  function automatic logic [15:0] period_of(input logic [4:0] code, input int BAND_SH);
    logic [2:0]  band;
    logic [1:0]  step;
    logic [15:0] g;
    band = code[4:2];
    step = ~code[1:0];
    g    = 16'(1 << BAND_SH) >> band;
    return ((g - 16'd1) << 2) + g * (16'(step) + 16'd1);
  endfunction
endpackage

// File: rtl/lfo_timebase.sv
module lfo_timebase #(
  parameter int RATE_W  = 5,
  parameter int BAND_SH = 7,
  parameter int CNT_W   = BAND_SH + 3,
  parameter int PH_W    = lfo_pkg::PH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              rate_load,
  input  logic              phase_restart,
  output logic [PH_W-1:0]   phase_q,
  output logic [CNT_W-1:0]  cnt_q
);
  logic [CNT_W-1:0] reload_v;
  assign reload_v = CNT_W'(lfo_pkg::period_of(5'(rate_code), BAND_SH));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      cnt_q   <= reload_v;
    end else if (phase_restart || rate_load) begin
      cnt_q <= reload_v;
      if (phase_restart) phase_q <= '0;
    end else if (tick) begin
      if (cnt_q == CNT_W'(1)) begin
        phase_q <= phase_q + 1'b1;
        cnt_q   <= reload_v;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/lfo_shaper.sv
module lfo_shaper #(
  parameter bit PITCH   = 1'b0,
  parameter int DEPTH_W = 3,
  parameter int PH_W    = lfo_pkg::PH_W
) (
  input  logic [PH_W-1:0]    phase,
  input  lfo_pkg::wave_e     wave,
  input  logic [DEPTH_W-1:0] depth,
  output logic [PH_W-1:0]    value
);
  localparam int SH_W = DEPTH_W + 1;
  logic [PH_W-1:0] tri_v, noise_v, sqr_v, tri_sel, shaped;
  logic [SH_W-1:0] shamt;

  assign tri_v   = {phase[PH_W-2:0] ^ {(PH_W-1){phase[PH_W-1]}}, 1'b0};
  assign noise_v = (phase >> 3) ^ (phase << 3) ^ (phase & 8'hE3);

  generate
    if (PITCH) begin : g_pitch
      assign sqr_v   = phase[PH_W-1] ? 8'h80 : 8'h7F;
      assign tri_sel = tri_v - 8'h80;
    end else begin : g_amp
      assign sqr_v   = phase[PH_W-1] ? 8'hFF : 8'h00;
      assign tri_sel = tri_v;
    end
  endgenerate

  always_comb begin
    unique case (wave)
      lfo_pkg::WV_SAW: shaped = phase;
      lfo_pkg::WV_SQR: shaped = sqr_v;
      lfo_pkg::WV_TRI: shaped = tri_sel;
      default:         shaped = noise_v;
    endcase
  end

  assign shamt = SH_W'(PH_W) - SH_W'(depth);
  assign value = shaped >> shamt;
endmodule

// File: rtl/lfo_core.sv
module lfo_core #(
  parameter int RATE_W  = 5,
  parameter int DEPTH_W = 3,
  parameter int BAND_SH = 7,
  parameter int CNT_W   = BAND_SH + 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [RATE_W-1:0]  rate_code,
  input  logic               rate_load,
  input  logic               phase_restart,
  input  logic [1:0]         amp_wave,
  input  logic [DEPTH_W-1:0] amp_depth,
  input  logic [1:0]         pitch_wave,
  input  logic [DEPTH_W-1:0] pitch_depth,
  output logic [7:0]         amp_mod,
  output logic [7:0]         pitch_mod
);
  logic [7:0]       phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       amp_v, pitch_v;

  lfo_timebase #(.RATE_W(RATE_W), .BAND_SH(BAND_SH), .CNT_W(CNT_W), .PH_W(8)) tb_u (
    .clk(clk), .rst(rst), .tick(tick), .rate_code(rate_code),
    .rate_load(rate_load), .phase_restart(phase_restart),
    .phase_q(phase_q), .cnt_q(cnt_q)
  );

  lfo_shaper #(.PITCH(1'b0), .DEPTH_W(DEPTH_W), .PH_W(8)) amp_u (
    .phase(phase_q), .wave(lfo_pkg::wave_e'(amp_wave)), .depth(amp_depth), .value(amp_v)
  );

  lfo_shaper #(.PITCH(1'b1), .DEPTH_W(DEPTH_W), .PH_W(8)) pitch_u (
    .phase(phase_q), .wave(lfo_pkg::wave_e'(pitch_wave)), .depth(pitch_depth), .value(pitch_v)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      amp_mod   <= '0;
      pitch_mod <= '0;
    end else begin
      amp_mod   <= amp_v;
      pitch_mod <= pitch_v;
    end
  end
endmodule

// File: rtl/lfo_core_chk.sv
module lfo_core_chk #(
  parameter int DEPTH_W = 3,
  parameter int CNT_W   = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               tick,
  input logic               rate_load,
  input logic               phase_restart,
  input logic [DEPTH_W-1:0] amp_depth,
  input logic [1:0]         pitch_wave,
  input logic [DEPTH_W-1:0] pitch_depth,
  input logic [7:0]         amp_mod,
  input logic [7:0]         pitch_mod,
  input logic [7:0]         phase,
  input logic [CNT_W-1:0]   cnt
);
  AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (rst) cnt != '0); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) cnt <= CNT_W'(1020)); // R1
  AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!tick && !phase_restart) |=> $stable(phase)); // R2
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    phase_restart |=> phase == 8'd0); // R3
  AST_LOAD_KEEPS_PHASE: assert property (@(posedge clk) disable iff (rst)
    (rate_load && !phase_restart) |=> $stable(phase)); // R4
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && !phase_restart && !rate_load) |=> (phase == $past(phase) || phase == $past(phase) + 8'd1)); // R11
  AST_AMP_DEPTH0: assert property (@(posedge clk) disable iff (rst)
    amp_depth == '0 |=> amp_mod == 8'd0); // R9
  AST_PITCH_SQR: assert property (@(posedge clk) disable iff (rst)
    (pitch_wave == 2'd1 && pitch_depth == DEPTH_W'(7)) |=> (pitch_mod == 8'h40 || pitch_mod == 8'h3F)); // R7
endmodule

bind lfo_core lfo_core_chk #(.DEPTH_W(DEPTH_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .tick(tick), .rate_load(rate_load),
  .phase_restart(phase_restart), .amp_depth(amp_depth),
  .pitch_wave(pitch_wave), .pitch_depth(pitch_depth),
  .amp_mod(amp_mod), .pitch_mod(pitch_mod), .phase(phase_q), .cnt(cnt_q)
);

// File: tb/lfo_core_tb_top.sv
`timescale 1ns/1ps
module lfo_core_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [4:0] rate_code = 5'd31;
  logic       rate_load = 1'b0;
  logic       phase_restart = 1'b0;
  logic [1:0] amp_wave = 2'd0;
  logic [2:0] amp_depth = 3'd7;
  logic [1:0] pitch_wave = 2'd0;
  logic [2:0] pitch_depth = 3'd7;
  logic [7:0] amp_mod, pitch_mod;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int cyc = 0;

  always #10 clk = ~clk;

  lfo_core dut_i (
    .clk(clk), .rst(rst), .tick(tick), .rate_code(rate_code),
    .rate_load(rate_load), .phase_restart(phase_restart),
    .amp_wave(amp_wave), .amp_depth(amp_depth),
    .pitch_wave(pitch_wave), .pitch_depth(pitch_depth),
    .amp_mod(amp_mod), .pitch_mod(pitch_mod)
  );

  // Bench model written from the requirements
  function automatic int period(input int n);
    int g;
    g = 128 >> (n >> 2);
    return 4 * (g - 1) + g * (((~n) & 3) + 1);
  endfunction

  function automatic logic [7:0] wave_val(input logic [7:0] p, input int w, input int d, input bit pitch);
    logic [7:0] v, t;
    t = {p[6:0] ^ (p[7] ? 7'h7F : 7'h00), 1'b0};
    case (w)
      0: v = p;
      1: v = pitch ? (p[7] ? 8'h80 : 8'h7F) : (p[7] ? 8'hFF : 8'h00);
      2: v = pitch ? t - 8'h80 : t;
      default: v = 8'((p >> 3) ^ (p << 3) ^ (p & 8'hE3));
    endcase
    return (d == 0) ? 8'd0 : (v >> (8 - d));
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(input logic [4:0] code);
    rate_code = code;
    phase_restart = 1'b1;
    cycles(1);
    phase_restart = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    cycles(n);
    tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // code, ticks, amp wave, amp depth, pitch wave, pitch depth
  localparam int NV = 8;
  localparam int VEC [NV][6] = '{
    '{31, 200, 0, 7, 3, 7},
    '{30, 300, 1, 7, 1, 7},
    '{13, 590, 2, 7, 2, 6},
    '{31, 258, 3, 5, 0, 3},
    '{ 0, 3059, 0, 0, 1, 0},
    '{31, 129, 2, 4, 2, 7},
    '{30, 511, 1, 7, 3, 4},
    '{31, 255, 2, 7, 1, 7}
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 100000);
      finish_run();
    end
  end

  initial begin
    cycles(3);
    check("R10 reset amp", amp_mod, 8'd0);
    check("R10 reset pitch", pitch_mod, 8'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [7:0] ph;
      restart(5'(VEC[i][0]));
      amp_wave = 2'(VEC[i][2]);  amp_depth = 3'(VEC[i][3]);
      pitch_wave = 2'(VEC[i][4]); pitch_depth = 3'(VEC[i][5]);
      ticks(VEC[i][1]);
      cycles(2);
      ph = 8'((VEC[i][1] / period(VEC[i][0])) % 256);
      // R1 R2 R5 R6 R7 R8 R9 over the table
      check($sformatf("R2 vec%0d amp", i), amp_mod, wave_val(ph, VEC[i][2], VEC[i][3], 1'b0));
      check($sformatf("R7 vec%0d pitch", i), pitch_mod, wave_val(ph, VEC[i][4], VEC[i][5], 1'b1));
    end

    // R1 slowest code: one tick short of a step leaves phase 0
    amp_wave = 2'd0; amp_depth = 3'd7; pitch_wave = 2'd2; pitch_depth = 3'd7;
    restart(5'd0);
    ticks(1019);
    cycles(2);
    check("R1 code0 before step", pitch_mod, 8'h40);
    ticks(1);
    cycles(2);
    check("R1 code0 after step", pitch_mod, 8'h41);

    // R4 and R11: reload mid-period with a tick in the same cycle
    restart(5'd13);
    ticks(424);
    rate_load = 1'b1; tick = 1'b1;
    cycles(1);
    rate_load = 1'b0; tick = 1'b0;
    cycles(2);
    check("R4 phase kept on load", pitch_mod, 8'h43);
    ticks(107);
    cycles(2);
    check("R11 load restarts period", pitch_mod, 8'h43);
    ticks(1);
    cycles(2);
    check("R4 step after full period", pitch_mod, 8'h44);

    // R3 and R11: restart with a tick in the same cycle
    restart(5'd31);
    ticks(5);
    cycles(2);
    check("R2 phase five", pitch_mod, 8'h45);
    tick = 1'b1; phase_restart = 1'b1;
    cycles(1);
    tick = 1'b0; phase_restart = 1'b0;
    cycles(2);
    check("R3 restart to zero", pitch_mod, 8'h40);
    check("R3 amp saw zero", amp_mod, 8'h00);

    // R10: output follows a select change one clock later
    ticks(200);
    cycles(2);
    amp_wave = 2'd1;
    @(posedge clk); #1;
    check("R5 square after one clock", amp_mod, 8'h7F);

    finish_run();
  end
endmodule